// File: doc/BRIEF.md
# Load/Store Unit with Register-Aliased Address Window

This block is the memory stage of a load/store processor. Only loads and stores come through it; every other operation stays between registers and never reaches this unit. For each request it forms one effective address: an index register value plus a signed 13-bit displacement. A zero index value gives absolute addressing. A zero displacement gives register-indirect addressing. It supports word, halfword and byte transfers. Narrow loads are zero- or sign-extended to the full word.

One comparison on the effective address decides where the access goes. If the address lies in a reserved window (a base address and a power-of-two size), the unit reads or writes the on-chip window registers through a register-file port. The word offset inside the window picks the physical register. This lets pointers to register-held variables work like ordinary memory pointers. Any other address goes to a plain external memory port.

Every access takes two cycles. The first cycle forms the address. The second cycle performs the access. A one-cycle completion pulse follows, and it carries the load result and an alignment error flag.

Top module: `lsu_regmap`

## Requirements
- R1: The effective address is `req_base` plus `req_disp` sign-extended to 32 bits, modulo 2^32. The memory port shows this address with bits [1:0] forced to zero.
- R2: `req_op` is encoded as follows: 0 load word, 1 load half unsigned, 2 load half signed, 3 load byte unsigned, 4 load byte signed, 5 store word, 6 store half, 7 store byte. Stores assert the write strobe of the selected port, and loads keep it low.
- R3: An address hits the window when `(EA & ~(RF_WORDS*4-1)) == REG_BASE`. With the defaults this is 0xFFFFFE00..0xFFFFFFFF. A hit uses only the register port, with index EA[8:2]. A miss uses only the memory port. The two ports are never active together.
- R4: A request is taken when `req_valid` is high while the unit is idle. The selected port is active for exactly the next cycle, and `done` is high for one cycle in the cycle after that. `req_valid` during the access cycle is ignored.
- R5: Byte enables follow little-endian lanes. A byte access enables lane EA[1:0] only. A halfword access enables 0b0011 when EA[1] is 0 and 0b1100 when EA[1] is 1. A word access enables 0b1111.
- R6: Store data is replicated across the word: the byte value four times, the halfword value twice, the word unchanged.
- R7: A load returns the selected lane or lanes in `ld_data`, zero-extended for the unsigned variants and sign-extended for the signed variants.
- R8: A halfword access with EA[0]=1, or a word access with EA[1:0]≠0, is misaligned. It activates neither port, so a misaligned store changes no stored value. It still completes with `done`, with `misalign` high and `ld_data` equal to 0.
- R9: After reset, `done`, `misalign`, `mem_req`, `rf_req` and `ld_data` are all 0.
- R10: A store completes with `ld_data` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Access variant (R2 encoding) |
| req_base | input | 32 | Index register value |
| req_disp | input | 13 | Signed displacement |
| req_wdata | input | 32 | Store data (low bits for narrow stores) |
| mem_req | output | 1 | External memory access cycle |
| mem_we | output | 1 | External memory write strobe |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the access cycle |
| rf_req | output | 1 | Window register access cycle |
| rf_we | output | 1 | Window register write strobe |
| rf_idx | output | 7 | Physical window register index |
| rf_be | output | 4 | Register byte enables |
| rf_wdata | output | 32 | Register write data |
| rf_rdata | input | 32 | Register read data, valid in the access cycle |
| done | output | 1 | One-cycle completion pulse |
| misalign | output | 1 | Alignment error, valid with done |
| ld_data | output | 32 | Load result, valid with done |

## Verification
Port selection, address, index, byte enables and replicated store data appear in the cycle right after the accepting edge. The completion pulse, the alignment flag and the load result appear one cycle later still. The reference model predicts both phases for every request. It compares the request phase one falling edge after the request is driven and the completion phase one falling edge after that, so each check samples halfway between the edges that produce the value. Stores are later read back through the same ports, which shows their effect, including the absence of any write for a misaligned store. Requests driven during the access cycle are checked to cause no port activity in the following cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [2:0] {
    OP_LD_W  = 3'd0,
    OP_LD_HU = 3'd1,
    OP_LD_HS = 3'd2,
    OP_LD_BU = 3'd3,
    OP_LD_BS = 3'd4,
    OP_ST_W  = 3'd5,
    OP_ST_H  = 3'd6,
    OP_ST_B  = 3'd7
  } lsu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } lsu_size_e;

  typedef struct packed {
    logic      is_store;
    logic      sign_ext;
    lsu_size_e size;
  } lsu_dec_t;

  function automatic lsu_dec_t lsu_decode(lsu_op_e op);
    lsu_dec_t d;
    d = '{is_store: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
    case (op)
      OP_LD_W:  d = '{is_store: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
      OP_LD_HU: d = '{is_store: 1'b0, sign_ext: 1'b0, size: SZ_HALF};
      OP_LD_HS: d = '{is_store: 1'b0, sign_ext: 1'b1, size: SZ_HALF};
      OP_LD_BU: d = '{is_store: 1'b0, sign_ext: 1'b0, size: SZ_BYTE};
      OP_LD_BS: d = '{is_store: 1'b0, sign_ext: 1'b1, size: SZ_BYTE};
      OP_ST_W:  d = '{is_store: 1'b1, sign_ext: 1'b0, size: SZ_WORD};
      OP_ST_H:  d = '{is_store: 1'b1, sign_ext: 1'b0, size: SZ_HALF};
      OP_ST_B:  d = '{is_store: 1'b1, sign_ext: 1'b0, size: SZ_BYTE};
      default:  d = '{is_store: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int unsigned              ADDR_W   = 32,
  parameter int unsigned              DATA_W   = 32,
  parameter int unsigned              DISP_W   = 13,
  parameter int unsigned              RF_WORDS = 128,
  parameter logic [ADDR_W-1:0]        REG_BASE = 32'hFFFF_FE00
) (
  input  logic [ADDR_W-1:0]           base,
  input  logic [DISP_W-1:0]           disp,
  input  lsu_size_e                   size,
  output logic [ADDR_W-1:0]           ea,
  output logic                        win_hit,
  output logic [$clog2(RF_WORDS)-1:0] win_idx,
  output logic [DATA_W/8-1:0]         lane_be,
  output logic                        misaligned
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFS_W = $clog2(LANES);
  localparam int unsigned IDX_W = $clog2(RF_WORDS);
  localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'(RF_WORDS * LANES - 1);

  logic [ADDR_W-1:0] disp_ext;
  logic [OFS_W-1:0]  ofs;

  always_comb begin
    disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    ea       = base + disp_ext;
    ofs      = ea[OFS_W-1:0];
    win_hit  = ((ea & ~WIN_MASK) == REG_BASE);
    win_idx  = ea[IDX_W+OFS_W-1:OFS_W];
  end

  always_comb begin
    lane_be    = '0;
    misaligned = 1'b0;
    case (size)
      SZ_BYTE: begin
        lane_be    = LANES'(1) << ofs;
        misaligned = 1'b0;
      end
      SZ_HALF: begin
        lane_be    = LANES'(3) << {ofs[OFS_W-1:1], 1'b0};
        misaligned = ofs[0];
      end
      default: begin
        lane_be    = '1;
        misaligned = |ofs;
      end
    endcase
  end

endmodule

// File: rtl/lsu_lane.sv
module lsu_lane
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  lsu_size_e                   st_size,
  input  logic [DATA_W-1:0]           st_data,
  output logic [DATA_W-1:0]           st_rep,
  input  lsu_size_e                   ld_size,
  input  logic                        ld_sign,
  input  logic [$clog2(DATA_W/8)-1:0] ld_ofs,
  input  logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-1:0]           ld_val
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFS_W = $clog2(LANES);

  logic [7:0]  rd_lane [LANES];
  logic [7:0]  byte_v;
  logic [15:0] half_v;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_lane[g] = rdata[8*g +: 8];
  end

  always_comb begin
    st_rep = st_data;
    case (st_size)
      SZ_BYTE: for (int i = 0; i < LANES; i++)   st_rep[8*i  +: 8]  = st_data[7:0];
      SZ_HALF: for (int i = 0; i < LANES/2; i++) st_rep[16*i +: 16] = st_data[15:0];
      default: st_rep = st_data;
    endcase
  end

  always_comb begin
    byte_v = rd_lane[ld_ofs];
    half_v = {rd_lane[{ld_ofs[OFS_W-1:1], 1'b1}], rd_lane[{ld_ofs[OFS_W-1:1], 1'b0}]};
    case (ld_size)
      SZ_BYTE: ld_val = {{(DATA_W-8){ld_sign & byte_v[7]}}, byte_v};
      SZ_HALF: ld_val = {{(DATA_W-16){ld_sign & half_v[15]}}, half_v};
      default: ld_val = rdata;
    endcase
  end

endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   ea_d,
  input  logic                hit_d,
  input  logic                mis_d,
  input  logic                st_d,
  input  logic                sgn_d,
  input  lsu_size_e           size_d,
  input  logic [DATA_W/8-1:0] be_d,
  input  logic [IDX_W-1:0]    idx_d,
  input  logic [DATA_W-1:0]   wd_d,
  input  logic [DATA_W-1:0]   ld_val,
  output logic                acc_q,
  output logic [ADDR_W-1:0]   ea_q,
  output logic                hit_q,
  output logic                mis_q,
  output logic                st_q,
  output logic                sgn_q,
  output lsu_size_e           size_q,
  output logic [DATA_W/8-1:0] be_q,
  output logic [IDX_W-1:0]    idx_q,
  output logic [DATA_W-1:0]   wd_q,
  output logic                done_q,
  output logic                mis_out_q,
  output logic [DATA_W-1:0]   ld_q
);

  logic              acc_d;
  logic              done_d;
  logic              mis_out_d;
  logic [DATA_W-1:0] ld_d;
  logic              cap_en;

  always_comb begin
    acc_d     = req_valid & ~acc_q;
    cap_en    = acc_d;
    done_d    = acc_q;
    mis_out_d = acc_q & mis_q;
    ld_d      = (acc_q & ~st_q & ~mis_q) ? ld_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= 1'b0;
      done_q    <= 1'b0;
      mis_out_q <= 1'b0;
      ld_q      <= '0;
    end else begin
      acc_q     <= acc_d;
      done_q    <= done_d;
      mis_out_q <= mis_out_d;
      ld_q      <= ld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      ea_q   <= ea_d;
      hit_q  <= hit_d;
      mis_q  <= mis_d;
      st_q   <= st_d;
      sgn_q  <= sgn_d;
      size_q <= size_d;
      be_q   <= be_d;
      idx_q  <= idx_d;
      wd_q   <= wd_d;
    end
  end

  AST_ACCESS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> !acc_q);                                               // R4
  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(acc_q));                                        // R4
  AST_STORE_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(st_q)) |-> (ld_q == '0));                       // R10

endmodule

// File: rtl/lsu_regmap.sv
module lsu_regmap
  import lsu_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       DISP_W   = 13,
  parameter int unsigned       RF_WORDS = 128,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'hFFFF_FE00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [2:0]                  req_op,
  input  logic [ADDR_W-1:0]           req_base,
  input  logic [DISP_W-1:0]           req_disp,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [DATA_W/8-1:0]         mem_be,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic                        rf_req,
  output logic                        rf_we,
  output logic [$clog2(RF_WORDS)-1:0] rf_idx,
  output logic [DATA_W/8-1:0]         rf_be,
  output logic [DATA_W-1:0]           rf_wdata,
  input  logic [DATA_W-1:0]           rf_rdata,
  output logic                        done,
  output logic                        misalign,
  output logic [DATA_W-1:0]           ld_data
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFS_W = $clog2(LANES);
  localparam int unsigned IDX_W = $clog2(RF_WORDS);

  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  lsu_dec_t          dec;
  logic [ADDR_W-1:0] ea_d;
  logic              hit_d, mis_d;
  logic [IDX_W-1:0]  idx_d;
  logic [LANES-1:0]  be_d;
  logic [DATA_W-1:0] wd_d;

  logic              acc_q, hit_q, mis_q, st_q, sgn_q, done_q, mis_out_q;
  logic [ADDR_W-1:0] ea_q;
  lsu_size_e         size_q;
  logic [LANES-1:0]  be_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] wd_q, ld_q, ld_val, rd_sel;

  always_comb dec = lsu_decode(lsu_op_e'(req_op));

  lsu_agen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W),
    .RF_WORDS(RF_WORDS), .REG_BASE(REG_BASE)
  ) agen_i (
    .base(req_base), .disp(req_disp), .size(dec.size),
    .ea(ea_d), .win_hit(hit_d), .win_idx(idx_d),
    .lane_be(be_d), .misaligned(mis_d)
  );

  always_comb rd_sel = hit_q ? rf_rdata : mem_rdata;

  lsu_lane #(.DATA_W(DATA_W)) lane_i (
    .st_size(dec.size), .st_data(req_wdata), .st_rep(wd_d),
    .ld_size(size_q), .ld_sign(sgn_q), .ld_ofs(ea_q[OFS_W-1:0]),
    .rdata(rd_sel), .ld_val(ld_val)
  );

  lsu_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid),
    .ea_d(ea_d), .hit_d(hit_d), .mis_d(mis_d), .st_d(dec.is_store),
    .sgn_d(dec.sign_ext), .size_d(dec.size), .be_d(be_d), .idx_d(idx_d),
    .wd_d(wd_d), .ld_val(ld_val),
    .acc_q(acc_q), .ea_q(ea_q), .hit_q(hit_q), .mis_q(mis_q), .st_q(st_q),
    .sgn_q(sgn_q), .size_q(size_q), .be_q(be_q), .idx_q(idx_q), .wd_q(wd_q),
    .done_q(done_q), .mis_out_q(mis_out_q), .ld_q(ld_q)
  );

  always_comb begin
    mem_req   = acc_q & ~mis_q & ~hit_q;
    mem_we    = mem_req & st_q;
    mem_addr  = {ea_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    mem_be    = be_q;
    mem_wdata = wd_q;
    rf_req    = acc_q & ~mis_q & hit_q;
    rf_we     = rf_req & st_q;
    rf_idx    = idx_q;
    rf_be     = be_q;
    rf_wdata  = wd_q;
    done      = done_q;
    misalign  = mis_out_q;
    ld_data   = ld_q;
  end

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_req && rf_req));                                           // R3
  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    misalign |-> $past(!mem_req && !rf_req));                        // R8
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((mem_req || rf_req) && size_q == SZ_BYTE) |-> ($countones(be_q) == 1)); // R5

endmodule

// File: tb/lsu_regmap_tb_top.sv
module lsu_regmap_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] LDW = 3'd0, LDHU = 3'd1, LDHS = 3'd2, LDBU = 3'd3,
                         LDBS = 3'd4, STW = 3'd5, STH = 3'd6, STB = 3'd7;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [2:0] req_op;
  logic [31:0] req_base, req_wdata;
  logic [12:0] req_disp;
  logic mem_req, mem_we, rf_req, rf_we, done, misalign;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_wdata, rf_rdata, ld_data;
  logic [3:0] mem_be, rf_be;
  logic [6:0] rf_idx;

  logic [31:0] mem_arr [256];
  logic [31:0] rf_arr  [128];

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_regmap dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_disp(req_disp), .req_wdata(req_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_req(rf_req), .rf_we(rf_we), .rf_idx(rf_idx), .rf_be(rf_be),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .done(done), .misalign(misalign), .ld_data(ld_data)
  );

  always_comb mem_rdata = mem_arr[mem_addr[9:2]];
  always_comb rf_rdata  = rf_arr[rf_idx];

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (mem_req && mem_we && mem_be[i]) mem_arr[mem_addr[9:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
      if (rf_req && rf_we && rf_be[i])    rf_arr[rf_idx][8*i +: 8]         <= rf_wdata[8*i +: 8];
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [31:0] base,
                        input logic [12:0] disp, input logic [31:0] wd, input bit noise);
    logic [31:0] ea, rep, word, exp_ld;
    logic hit, mis, st;
    logic [3:0] be;
    int sz;
    ea  = base + {{19{disp[12]}}, disp};
    hit = (ea & ~32'h1FF) == 32'hFFFF_FE00;
    st  = (op >= STW);
    sz  = (op == LDW || op == STW) ? 2 : (op == LDHU || op == LDHS || op == STH) ? 1 : 0;
    mis = (sz == 2 && ea[1:0] != 2'b00) || (sz == 1 && ea[0]);
    be  = (sz == 2) ? 4'hF : (sz == 1) ? (ea[1] ? 4'hC : 4'h3) : (4'h1 << ea[1:0]);
    rep = (sz == 2) ? wd : (sz == 1) ? {2{wd[15:0]}} : {4{wd[7:0]}};
    req_valid = 1'b1; req_op = op; req_base = base; req_disp = disp; req_wdata = wd;
    @(negedge clk);
    if (noise) begin
      req_op = STW; req_base = 32'h0000_0300; req_disp = 13'd0; req_wdata = 32'hDEAD_BEEF;
    end else req_valid = 1'b0;
    chk("R3 mem_req", 32'(mem_req), 32'(!hit && !mis));
    chk("R3 rf_req", 32'(rf_req), 32'(hit && !mis));
    chk("R4 done low in access cycle", 32'(done), 0);
    if (!mis && !hit) begin
      chk("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
      chk("R5 mem_be", 32'(mem_be), 32'(be));
      chk("R2 mem_we", 32'(mem_we), 32'(st));
      if (st) chk("R6 mem_wdata", mem_wdata, rep);
    end
    if (!mis && hit) begin
      chk("R3 rf_idx", 32'(rf_idx), 32'(ea[8:2]));
      chk("R5 rf_be", 32'(rf_be), 32'(be));
      chk("R2 rf_we", 32'(rf_we), 32'(st));
      if (st) chk("R6 rf_wdata", rf_wdata, rep);
    end
    word = hit ? rf_arr[ea[8:2]] : mem_arr[ea[9:2]];
    case (op)
      LDW:  exp_ld = word;
      LDHU: exp_ld = {16'h0, ea[1] ? word[31:16] : word[15:0]};
      LDHS: exp_ld = ea[1] ? {{16{word[31]}}, word[31:16]} : {{16{word[15]}}, word[15:0]};
      LDBU: exp_ld = {24'h0, word[8*ea[1:0] +: 8]};
      LDBS: exp_ld = {{24{word[8*ea[1:0]+7]}}, word[8*ea[1:0] +: 8]};
      default: exp_ld = 32'h0;
    endcase
    if (mis) exp_ld = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4 done pulse", 32'(done), 1);
    chk("R8 misalign", 32'(misalign), 32'(mis));
    chk(st ? "R10 store ld_data" : "R7 ld_data", ld_data, exp_ld);
    chk("R4 no access after busy request", 32'(mem_req | rf_req), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_arr[i] = 32'h5A00_0000 ^ (i * 32'h0101_0103);
    for (int i = 0; i < 128; i++) rf_arr[i]  = 32'h00C0_0000 ^ (i * 32'h0303_0101);
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_base = '0; req_disp = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R9 done at reset", 32'(done), 0);
    chk("R9 misalign at reset", 32'(misalign), 0);
    chk("R9 ports idle at reset", 32'(mem_req | rf_req), 0);
    chk("R9 ld_data at reset", ld_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_op(STW,  32'h100, 13'd0, 32'h1122_3344, 0);   // R1 register indirect
    run_op(LDW,  32'h100, 13'd0, 32'h0, 0);
    run_op(STB,  32'h100, 13'd1, 32'h0000_00AB, 0);   // R5 R6
    run_op(LDBU, 32'h101, 13'd0, 32'h0, 0);           // R7
    run_op(LDBS, 32'h101, 13'd0, 32'h0, 0);
    run_op(LDBS, 32'h100, 13'd0, 32'h0, 0);           // positive byte 0x44
    run_op(STH,  32'h104, 13'd2, 32'hBEEF_8001, 0);
    run_op(LDHS, 32'h106, 13'd0, 32'h0, 0);
    run_op(LDHU, 32'h106, 13'd0, 32'h0, 0);
    run_op(LDHS, 32'h104, 13'd0, 32'h0, 0);
    run_op(LDW,  32'h200, 13'h1FFC, 32'h0, 0);        // R1 negative disp
    run_op(LDBU, 32'h0,   13'h0FFF, 32'h0, 0);        // R1 max disp, absolute
    run_op(STW,  32'h0,   13'h1FFC, 32'hCAFE_F00D, 0); // R3 absolute into window top
    run_op(LDW,  32'h0,   13'h1FFC, 32'h0, 0);
    run_op(STB,  32'hFFFF_FE00, 13'd3, 32'h0000_0077, 0); // R3 window start
    run_op(LDW,  32'hFFFF_FE00, 13'd0, 32'h0, 0);
    run_op(LDW,  32'hFFFF_FE00, 13'h1FFC, 32'h0, 0);  // R3 just below window
    run_op(LDHU, 32'h101, 13'd0, 32'h0, 0);           // R8
    run_op(LDW,  32'h102, 13'd0, 32'h0, 0);           // R8
    run_op(STW,  32'hFFFF_FE01, 13'd0, 32'h9999_9999, 0); // R8 no write
    run_op(LDW,  32'hFFFF_FE00, 13'd0, 32'h0, 0);
    run_op(STH,  32'h103, 13'd0, 32'h1234_5678, 0);   // R8 no write
    run_op(LDW,  32'h100, 13'd0, 32'h0, 0);
    run_op(LDW,  32'h100, 13'd0, 32'h0, 1);           // R4 busy request ignored
    run_op(LDW,  32'h300, 13'd0, 32'h0, 0);           // R4 nothing written by ignored store

    for (int k = 0; k < 300; k++) begin
      logic [31:0] b;
      b = ($urandom_range(0, 1) == 1) ? 32'hFFFF_FE00 + ($urandom_range(0, 127) << 2)
                                      : 32'h100 + ($urandom_range(0, 127) << 2);
      run_op(3'($urandom_range(0, 7)), b + 32'($urandom_range(0, 3)),
             13'($urandom_range(0, 127)) - 13'd64, $urandom, bit'($urandom_range(0, 1)));
    end

    repeat (2) @(negedge clk);
    chk("R4 idle after traffic", 32'(done | mem_req | rf_req), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule